// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block takes an asynchronous serial line and rebuilds each frame into a parallel data word. A frame is one low start bit, DATA_W data bits, an optional even parity bit and one high stop bit. The line passes through a two-stage synchroniser. It is then sampled on a tick that runs at sixteen times the bit rate. That tick comes from a local clock divider set by the TICK_DIV parameter. A start edge counts as a frame only if the line is still low half a bit later, so short glitches are thrown away. After that check, each later bit is sampled in the middle of its bit period.

A finished frame goes into a holding register and raises a ready flag. Reading the word with the read strobe clears the ready flag. Three error flags stay set until they are cleared:

- a parity flag for a parity mismatch,
- an overrun flag for a frame that finishes while the previous word is still unread,
- a framing flag for a stop bit sampled low.

The error flags clear only when the error-clear control is written with zero. A separate validity output drops while the framing flag is set, because the held word cannot be trusted in that case. One interrupt line combines the ready flag and the three error flags. It is gated by an enable bit that software writes. A runtime input picks whether the first data bit on the line is the least or the most significant bit of the word.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, ready_o, par_err_o, ovr_err_o, frm_err_o, rie_o and irq_o are 0, and data_o is 0.
- R2: When a frame completes and ready_o is 0, data_o takes the received word and ready_o becomes 1.
- R3: A one-cycle pulse on rd_i clears ready_o. It does not change any error flag or data_o.
- R4: With msb_first_i = 0, the first data bit received becomes data_o[0]. With msb_first_i = 1, it becomes data_o[DATA_W-1].
- R5: With PAR_EN = 1, a parity bit follows the data bits. The parity is even: the data bits and the parity bit together hold an even number of ones. A mismatch sets par_err_o.
- R6: A stop bit sampled as 0 sets frm_err_o. While frm_err_o is 1, data_ok_o is 0. Otherwise data_ok_o equals ready_o.
- R7: A frame that completes while ready_o is 1 sets ovr_err_o. data_o keeps the unread word and ready_o stays 1.
- R8: The error flags are sticky. They clear together only on a cycle where err_clr_we_i = 1 and err_clr_wd_i = 0. A write with err_clr_wd_i = 1 has no effect, and the error clear leaves ready_o unchanged.
- R9: rie_o takes rie_wd_i on a cycle where rie_we_i = 1. irq_o is 1 exactly when rie_o is 1 and at least one of ready_o, par_err_o, ovr_err_o or frm_err_o is 1.
- R10: A low pulse on rx_i that is back high before the middle of the start bit does not start a frame, and ready_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| msb_first_i | input | 1 | Bit order select: 0 means the first bit is the LSB, 1 means the first bit is the MSB |
| rd_i | input | 1 | Read strobe for the data register |
| rie_we_i | input | 1 | Write enable for the interrupt enable bit |
| rie_wd_i | input | 1 | Value written to the interrupt enable bit |
| err_clr_we_i | input | 1 | Write enable for the error-clear control |
| err_clr_wd_i | input | 1 | Value written to the error-clear control; 0 clears the error flags |
| data_o | output | DATA_W | Received data word |
| ready_o | output | 1 | Data-ready flag |
| data_ok_o | output | 1 | Data word is ready and not marked invalid by a framing error |
| par_err_o | output | 1 | Parity error flag |
| ovr_err_o | output | 1 | Overrun error flag |
| frm_err_o | output | 1 | Framing error flag |
| rie_o | output | 1 | Receive interrupt enable |
| irq_o | output | 1 | Combined receive interrupt |

## Verification
The bench builds the block with TICK_DIV = 4, DATA_W = 8 and PAR_EN = 1. One bit then lasts 64 clock cycles, so an eleven-bit frame takes about 700 cycles. That is short enough to run both bit orders over several data patterns, a flipped parity bit, a low stop bit, two frames back to back with no read between them, and a start glitch shorter than half a bit, all in one run. Because parity is enabled, the parity-bit state of the frame sequencer is exercised. The low stop bit also sends the receiver through a rejected start, since the line is still low after the stop sample.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR   = 16;
  localparam int OSR_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_st_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int TICK_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              msb_first_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              stop_bad_o
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0]    LAST_BIT = BW'(DATA_W - 1);
  localparam logic [OSR_W-1:0] MID      = OSR_W'(HALF - 1);
  localparam logic [OSR_W-1:0] FULL     = OSR_W'(OSR - 1);

  rx_st_e            st_q;
  logic [OSR_W-1:0]  tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      sh_q       <= '0;
      par_acc_q  <= 1'b0;
      done_o     <= 1'b0;
      par_bad_o  <= 1'b0;
      stop_bad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: if (!rx_i) begin
            st_q   <= ST_START;
            tcnt_q <= '0;
          end
          ST_START: begin
            if (tcnt_q == MID) begin
              // start bit must still be low at mid-bit
              st_q      <= rx_i ? ST_IDLE : ST_DATA;
              tcnt_q    <= '0;
              bcnt_q    <= '0;
              par_acc_q <= 1'b0;
              par_bad_o <= 1'b0;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_DATA: begin
            if (tcnt_q == FULL) begin
              tcnt_q    <= '0;
              par_acc_q <= par_acc_q ^ rx_i;
              sh_q      <= msb_first_i ? {sh_q[DATA_W-2:0], rx_i}
                                       : {rx_i, sh_q[DATA_W-1:1]};
              if (bcnt_q == LAST_BIT) st_q <= PAR_EN ? ST_PAR : ST_STOP;
              else                    bcnt_q <= bcnt_q + 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_PAR: begin
            if (tcnt_q == FULL) begin
              tcnt_q    <= '0;
              par_bad_o <= par_acc_q ^ rx_i;
              st_q      <= ST_STOP;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_STOP: begin
            if (tcnt_q == FULL) begin
              tcnt_q     <= '0;
              done_o     <= 1'b1;
              stop_bad_o <= !rx_i;
              st_q       <= ST_IDLE;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q;
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              par_bad_i,
  input  logic              stop_bad_i,
  input  logic              rd_i,
  input  logic              rie_we_i,
  input  logic              rie_wd_i,
  input  logic              err_clr_we_i,
  input  logic              err_clr_wd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              rie_o
);
  logic err_clr;
  assign err_clr = err_clr_we_i && !err_clr_wd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      par_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      rie_o     <= 1'b0;
    end else begin
      if (rie_we_i) rie_o <= rie_wd_i;
      if (err_clr) begin
        par_err_o <= 1'b0;
        ovr_err_o <= 1'b0;
        frm_err_o <= 1'b0;
      end
      if (rd_i) ready_o <= 1'b0;
      // new events win over a clear in the same cycle
      if (done_i) begin
        if (ready_o && !rd_i) begin
          ovr_err_o <= 1'b1;
        end else begin
          data_o  <= frame_data_i;
          ready_o <= 1'b1;
          if (par_bad_i)  par_err_o <= 1'b1;
          if (stop_bad_i) frm_err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int TICK_DIV = 16,
  parameter int DATA_W   = 8,
  parameter bit PAR_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              msb_first_i,
  input  logic              rd_i,
  input  logic              rie_we_i,
  input  logic              rie_wd_i,
  input  logic              err_clr_we_i,
  input  logic              err_clr_wd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              data_ok_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              rie_o,
  output logic              irq_o
);
  logic              rx_s;
  logic              tick;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_par_bad;
  logic              frm_stop_bad;

  rx_sync #(.STAGES(2)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rx_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  rx_frame #(.DATA_W(DATA_W), .PAR_EN(PAR_EN)) frame_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .rx_i       (rx_s),
    .msb_first_i(msb_first_i),
    .done_o     (frm_done),
    .data_o     (frm_data),
    .par_bad_o  (frm_par_bad),
    .stop_bad_o (frm_stop_bad)
  );

  rx_status #(.DATA_W(DATA_W)) status_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (frm_done),
    .frame_data_i(frm_data),
    .par_bad_i   (frm_par_bad),
    .stop_bad_i  (frm_stop_bad),
    .rd_i        (rd_i),
    .rie_we_i    (rie_we_i),
    .rie_wd_i    (rie_wd_i),
    .err_clr_we_i(err_clr_we_i),
    .err_clr_wd_i(err_clr_wd_i),
    .data_o      (data_o),
    .ready_o     (ready_o),
    .par_err_o   (par_err_o),
    .ovr_err_o   (ovr_err_o),
    .frm_err_o   (frm_err_o),
    .rie_o       (rie_o)
  );

  assign data_ok_o = ready_o && !frm_err_o;
  assign irq_o     = rie_o && (ready_o || par_err_o || ovr_err_o || frm_err_o);
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              rie_we_i,
  input logic              rie_wd_i,
  input logic              err_clr_we_i,
  input logic              err_clr_wd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ready_o,
  input logic              data_ok_o,
  input logic              par_err_o,
  input logic              ovr_err_o,
  input logic              frm_err_o,
  input logic              rie_o,
  input logic              irq_o,
  input logic              done_i,
  input logic              stop_bad_i
);
  AST_LOAD_SETS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ready_o |=> ready_o); // R2
  AST_READ_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !ready_o); // R3
  AST_READ_KEEPS_ERRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !err_clr_we_i && par_err_o |=> par_err_o); // R3
  AST_STOP_LOW_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && stop_bad_i && !ready_o |=> frm_err_o && !data_ok_o); // R6
  AST_OVERRUN_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ready_o && !rd_i |=> ovr_err_o && ready_o && $stable(data_o)); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_we_i && !err_clr_wd_i && !done_i |=> !par_err_o && !ovr_err_o && !frm_err_o); // R8
  AST_FRM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o && !(err_clr_we_i && !err_clr_wd_i) |=> frm_err_o); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o && !(err_clr_we_i && !err_clr_wd_i) |=> ovr_err_o); // R8
  AST_RIE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rie_we_i |=> rie_o == $past(rie_wd_i)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rie_o |-> !irq_o); // R9
  AST_IRQ_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rie_o && ready_o |-> irq_o); // R9
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .rie_we_i    (rie_we_i),
  .rie_wd_i    (rie_wd_i),
  .err_clr_we_i(err_clr_we_i),
  .err_clr_wd_i(err_clr_wd_i),
  .data_o      (data_o),
  .ready_o     (ready_o),
  .data_ok_o   (data_ok_o),
  .par_err_o   (par_err_o),
  .ovr_err_o   (ovr_err_o),
  .frm_err_o   (frm_err_o),
  .rie_o       (rie_o),
  .irq_o       (irq_o),
  .done_i      (frm_done),
  .stop_bad_i  (frm_stop_bad)
);

// File: tb/uart_rx_flags_tb_top.sv
module uart_rx_flags_tb_top;
  localparam int TICK_DIV = 4;
  localparam int DATA_W   = 8;
  localparam bit PAR_EN   = 1'b1;
  localparam int BP       = 16 * TICK_DIV;

  typedef struct packed {
    logic [7:0] wire_bits; // bit i is the i-th data bit on the line
    logic       msb;
    logic       pflip;
    logic       sbad;
    logic [7:0] exp_data;
    logic       exp_pe;
    logic       exp_fe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h35, 1'b0, 1'b0, 1'b0, 8'h35, 1'b0, 1'b0},
    '{8'h35, 1'b1, 1'b0, 1'b0, 8'hAC, 1'b0, 1'b0},
    '{8'h01, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0},
    '{8'hF0, 1'b0, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b0},
    '{8'hA5, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},
    '{8'h3C, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},
    '{8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{8'hFF, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx = 1'b1;
  logic              msb_first = 1'b0;
  logic              rd = 1'b0;
  logic              rie_we = 1'b0;
  logic              rie_wd = 1'b0;
  logic              clr_we = 1'b0;
  logic              clr_wd = 1'b1;
  logic [DATA_W-1:0] data;
  logic              ready, data_ok, pe, ore, fe, rie, irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_rx_flags #(.TICK_DIV(TICK_DIV), .DATA_W(DATA_W), .PAR_EN(PAR_EN)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .msb_first_i (msb_first),
    .rd_i        (rd),
    .rie_we_i    (rie_we),
    .rie_wd_i    (rie_wd),
    .err_clr_we_i(clr_we),
    .err_clr_wd_i(clr_wd),
    .data_o      (data),
    .ready_o     (ready),
    .data_ok_o   (data_ok),
    .par_err_o   (pe),
    .ovr_err_o   (ore),
    .frm_err_o   (fe),
    .rie_o       (rie),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] w, input logic msb, input logic pflip,
                      input logic sbad);
    msb_first = msb;
    rx = 1'b0;
    idle(BP);
    for (int i = 0; i < DATA_W; i++) begin
      rx = w[i];
      idle(BP);
    end
    if (PAR_EN) begin
      rx = (^w) ^ pflip;
      idle(BP);
    end
    rx = !sbad;
    idle(BP);
    rx = 1'b1;
    idle(BP);
  endtask

  task automatic pulse_rd;
    rd = 1'b1; idle(1); rd = 1'b0; idle(1);
  endtask

  task automatic err_write(input logic v);
    clr_we = 1'b1; clr_wd = v; idle(1); clr_we = 1'b0; clr_wd = 1'b1; idle(1);
  endtask

  task automatic rie_write(input logic v);
    rie_we = 1'b1; rie_wd = v; idle(1); rie_we = 1'b0; idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 ready", ready, 0);
    chk("R1 pe", pe, 0);
    chk("R1 ore", ore, 0);
    chk("R1 fe", fe, 0);
    chk("R1 rie", rie, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", data, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 ready after release", ready, 0);

    rie_write(1'b1);
    chk("R9 rie write", rie, 1);

    foreach (VECS[k]) begin
      err_write(1'b0);
      chk("R8 flags cleared pe", pe, 0);
      chk("R8 flags cleared fe", fe, 0);
      send(VECS[k].wire_bits, VECS[k].msb, VECS[k].pflip, VECS[k].sbad);
      chk("R2 ready set", ready, 1);
      chk("R4 data order", data, VECS[k].exp_data);
      chk("R5 parity flag", pe, VECS[k].exp_pe);
      chk("R6 framing flag", fe, VECS[k].exp_fe);
      chk("R6 data_ok", data_ok, !VECS[k].exp_fe);
      chk("R9 irq with ready", irq, 1);
      pulse_rd();
      chk("R3 ready cleared", ready, 0);
      chk("R3 pe kept", pe, VECS[k].exp_pe);
      chk("R3 fe kept", fe, VECS[k].exp_fe);
      chk("R9 irq follows flags", irq, VECS[k].exp_pe | VECS[k].exp_fe);
      idle(BP);
    end

    // R7 overrun keeps first word
    err_write(1'b0);
    send(8'h11, 1'b0, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 ore set", ore, 1);
    chk("R7 data kept", data, 8'h11);
    chk("R7 ready kept", ready, 1);
    // R8 writing one has no effect
    err_write(1'b1);
    chk("R8 write one keeps ore", ore, 1);
    pulse_rd();
    chk("R3 read keeps ore", ore, 1);
    chk("R9 irq on ore only", irq, 1);
    err_write(1'b0);
    chk("R8 clear ore", ore, 0);
    chk("R9 irq drops", irq, 0);

    // R8 clear does not touch ready
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    err_write(1'b0);
    chk("R8 ready untouched by clear", ready, 1);
    chk("R2 data 5A", data, 8'h5A);
    pulse_rd();

    // R9 masked interrupt
    rie_write(1'b0);
    chk("R9 rie cleared", rie, 0);
    send(8'h77, 1'b0, 1'b1, 1'b0);
    chk("R9 irq masked", irq, 0);
    chk("R5 pe with mask", pe, 1);
    rie_write(1'b1);
    chk("R9 irq unmasked", irq, 1);
    pulse_rd();
    err_write(1'b0);

    // R10 short start glitch
    rx = 1'b0;
    idle(3 * TICK_DIV);
    rx = 1'b1;
    idle(3 * BP);
    chk("R10 glitch ignored ready", ready, 0);
    chk("R10 glitch ignored fe", fe, 0);
    send(8'hC3, 1'b1, 1'b0, 1'b0);
    chk("R10 next frame ok", data, 8'hC3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule